// File: doc/BRIEF.md
# Frequency Synthesiser Loop Core

This block is the digital heart of a phase-locked frequency synthesiser. It runs in one system clock domain and receives the reference oscillator and the prescaled oscillator as single-cycle tick strobes. A fixed divide-by-512 counter turns the reference ticks into the comparison rate. A 15-bit programmable down-counter divides the oscillator ticks by the programmed ratio, so the tuned frequency is the ratio times eight times the comparison frequency once the external divide-by-8 stage is counted. A two-flop phase/frequency comparator drives the up and down pump pulses.

A lock detector watches the width of every comparator pulse, measured in reference ticks, and raises the lock flag only after several clean comparison periods in a row. Four control bits set the pump current level, silence the pump, turn off the varactor drive, and route the comparison clock and the divider output to two test pins. The analog charge pump, the prescaler and the crystal oscillator sit outside this block.

Top module: `synth_loop_core`

## Requirements
- R1: After a synchronous active-high reset, with every control bit at 0, pump_up, pump_dn, lock, tst_cmp and tst_div are all 0.
- R2: One comparison event occurs per 512 reference ticks. The comparison clock level is high while the reference count, which steps by one per ref_tick from 0 after reset, lies in 256..511.
- R3: The divider loads ratio-1 when its count is 0 and a vco_tick arrives, and it counts down by one on every other vco_tick. It therefore emits one divider event per `ratio` ticks. The divider output level is high while the remaining count is below half of the loaded ratio (rounded down).
- R4: A new ratio takes effect only at the divider's terminal count. A change in mid-count leaves the current period and its output level unaltered.
- R5: A ratio of 0 or 1 is treated as 2.
- R6: A comparison event sets the up flop and a divider event sets the down flop. When both would be set, both clear on that edge, so coincident events produce no pulse and pump_up and pump_dn are never high together.
- R7: With t0=1, pump_up and pump_dn stay 0 while the comparator and the lock detector keep running.
- R8: With t1=1, tst_cmp carries the comparison clock level and tst_div carries the divider output level. With t1=0, both outputs are 0.
- R9: pump_hi equals cp (1 selects the high pump current), and drive_en is 0 when os=1 and 1 when os=0.
- R10: lock rises at a comparison event that completes 4 consecutive comparison periods in which no pulse reached 8 reference ticks.
- R11: A pulse that reaches 8 reference ticks clears lock on that edge and restarts the count of clean periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle strobe per reference oscillator period |
| vco_tick | input | 1 | One-cycle strobe per prescaled oscillator period |
| ratio | input | 15 | Programmable division ratio |
| cp | input | 1 | Pump current select (1 = high) |
| t0 | input | 1 | Pump disable |
| t1 | input | 1 | Test routing enable |
| os | input | 1 | Drive amplifier off |
| pump_up | output | 1 | Charge pump up pulse |
| pump_dn | output | 1 | Charge pump down pulse |
| pump_hi | output | 1 | Pump current level select |
| drive_en | output | 1 | Varactor drive amplifier enable |
| lock | output | 1 | Phase lock flag |
| tst_cmp | output | 1 | Test pin: comparison clock |
| tst_div | output | 1 | Test pin: divider output |

## Verification
The assertions check on every cycle that the pump outputs are never both high and stay quiet under pump disable, that the test pins are idle without routing, that the divider steps down by one per tick, that the loaded ratio changes only after a terminal count and never falls below the floor, and that lock rises only on a comparison event. Other behaviour has to be shown by the bench scenarios: how many periods lock takes to assert, how a delayed oscillator phase drops lock after exactly one wide pulse, whether a mid-count ratio change is deferred, and the duty of the two test levels. The bench compares every output against a behavioural model on each cycle and also counts levels and pulses over whole windows.

// File: rtl/synth_pkg.sv
package synth_pkg;

    localparam int RATIO_W     = 15;
    localparam int REF_LOG2    = 9;
    localparam int MIN_RATIO   = 2;
    localparam int LOCK_WIDTH  = 8;
    localparam int LOCK_CYCLES = 4;

    typedef struct packed {
        logic pump_hi;
        logic pump_off;
        logic test_route;
        logic drive_off;
    } ctl_t;

    typedef struct packed {
        logic up;
        logic dn;
    } pfd_t;

    function automatic pfd_t pfd_next(input pfd_t cur, input logic ref_ev, input logic div_ev);
        pfd_t n;
        n.up = cur.up | ref_ev;
        n.dn = cur.dn | div_ev;
        if (n.up && n.dn) begin
            n = '0;
        end
        return n;
    endfunction

endpackage

// File: rtl/synth_ref_div.sv
module synth_ref_div #(
    parameter int CNT_W = synth_pkg::REF_LOG2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic cmp_ev,
    output logic cmp_lvl
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign cmp_ev  = tick && (cnt == '1);
    assign cmp_lvl = cnt[CNT_W-1];
endmodule

// File: rtl/synth_prog_div.sv
module synth_prog_div #(
    parameter int W   = synth_pkg::RATIO_W,
    parameter int MIN = synth_pkg::MIN_RATIO
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] ratio,
    output logic         div_ev,
    output logic         div_lvl,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] cur_o
);
    localparam logic [W-1:0] FLOOR = W'(MIN);

    logic [W-1:0] cnt;
    logic [W-1:0] cur;
    logic [W-1:0] eff;

    always_comb begin
        eff = (ratio < FLOOR) ? FLOOR : ratio;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            cur <= FLOOR;
        end else if (tick) begin
            if (cnt == '0) begin
                cnt <= eff - 1'b1;
                cur <= eff;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign div_ev  = tick && (cnt == '0);
    assign div_lvl = cnt < (cur >> 1);
    assign cnt_o   = cnt;
    assign cur_o   = cur;
endmodule

// File: rtl/synth_pfd.sv
module synth_pfd
    import synth_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ref_ev,
    input  logic div_ev,
    output pfd_t st,
    output pfd_t st_nxt
);
    always_comb begin
        st_nxt = pfd_next(st, ref_ev, div_ev);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st <= st_nxt;
        end
    end
endmodule

// File: rtl/synth_lock_det.sv
module synth_lock_det #(
    parameter int LW = synth_pkg::LOCK_WIDTH,
    parameter int LC = synth_pkg::LOCK_CYCLES
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_tick,
    input  logic ref_ev,
    input  logic pulse_now,
    input  logic pulse_nxt,
    output logic locked
);
    localparam int WW = $clog2(LW + 1);
    localparam int GW = $clog2(LC + 1);

    logic [WW-1:0] w;
    logic [WW-1:0] w_n;
    logic [GW-1:0] good;
    logic [GW-1:0] good_inc;
    logic          bad;
    logic          wide;

    always_comb begin
        if (!pulse_now) begin
            w_n = '0;
        end else if (ref_tick && (w < WW'(LW))) begin
            w_n = w + 1'b1;
        end else begin
            w_n = w;
        end
        wide     = pulse_now && ref_tick && (w == WW'(LW - 1));
        good_inc = (good < GW'(LC)) ? good + 1'b1 : good;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            w      <= '0;
            good   <= '0;
            bad    <= 1'b0;
            locked <= 1'b0;
        end else begin
            w <= w_n;
            if (ref_ev) begin
                if (bad || wide) begin
                    good   <= '0;
                    locked <= 1'b0;
                end else begin
                    good   <= good_inc;
                    locked <= locked || (good_inc >= GW'(LC));
                end
                bad <= pulse_nxt && (w_n >= WW'(LW));
            end else if (wide) begin
                bad    <= 1'b1;
                good   <= '0;
                locked <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/synth_loop_core.sv
module synth_loop_core
    import synth_pkg::*;
#(
    parameter int RW  = RATIO_W,
    parameter int RL  = REF_LOG2,
    parameter int MR  = MIN_RATIO,
    parameter int LW  = LOCK_WIDTH,
    parameter int LC  = LOCK_CYCLES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ref_tick,
    input  logic          vco_tick,
    input  logic [RW-1:0] ratio,
    input  logic          cp,
    input  logic          t0,
    input  logic          t1,
    input  logic          os,
    output logic          pump_up,
    output logic          pump_dn,
    output logic          pump_hi,
    output logic          drive_en,
    output logic          lock,
    output logic          tst_cmp,
    output logic          tst_div
);
    ctl_t          ctl;
    pfd_t          pfd_q;
    pfd_t          pfd_d;
    logic          ref_ev;
    logic          cmp_lvl;
    logic          div_ev;
    logic          div_lvl;
    logic [RW-1:0] div_cnt;
    logic [RW-1:0] cur_ratio;

    always_comb begin
        ctl.pump_hi    = cp;
        ctl.pump_off   = t0;
        ctl.test_route = t1;
        ctl.drive_off  = os;
    end

    synth_ref_div #(.CNT_W(RL)) u_ref (
        .clk     (clk),
        .rst     (rst),
        .tick    (ref_tick),
        .cmp_ev  (ref_ev),
        .cmp_lvl (cmp_lvl)
    );

    synth_prog_div #(.W(RW), .MIN(MR)) u_div (
        .clk     (clk),
        .rst     (rst),
        .tick    (vco_tick),
        .ratio   (ratio),
        .div_ev  (div_ev),
        .div_lvl (div_lvl),
        .cnt_o   (div_cnt),
        .cur_o   (cur_ratio)
    );

    synth_pfd u_pfd (
        .clk    (clk),
        .rst    (rst),
        .ref_ev (ref_ev),
        .div_ev (div_ev),
        .st     (pfd_q),
        .st_nxt (pfd_d)
    );

    synth_lock_det #(.LW(LW), .LC(LC)) u_lock (
        .clk       (clk),
        .rst       (rst),
        .ref_tick  (ref_tick),
        .ref_ev    (ref_ev),
        .pulse_now (pfd_q.up | pfd_q.dn),
        .pulse_nxt (pfd_d.up | pfd_d.dn),
        .locked    (lock)
    );

    assign pump_up  = pfd_q.up & ~ctl.pump_off;
    assign pump_dn  = pfd_q.dn & ~ctl.pump_off;
    assign pump_hi  = ctl.pump_hi;
    assign drive_en = ~ctl.drive_off;
    assign tst_cmp  = ctl.test_route & cmp_lvl;
    assign tst_div  = ctl.test_route & div_lvl;
endmodule

// File: rtl/synth_loop_core_chk.sv
module synth_loop_core_chk #(
    parameter int W   = 15,
    parameter int MIN = 2
) (
    input logic         clk,
    input logic         rst,
    input logic         t0,
    input logic         t1,
    input logic         vco_tick,
    input logic         pump_up,
    input logic         pump_dn,
    input logic         tst_cmp,
    input logic         tst_div,
    input logic         lock,
    input logic         ref_ev,
    input logic         div_ev,
    input logic [W-1:0] div_cnt,
    input logic [W-1:0] cur_ratio
);
    AST_PUMP_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(pump_up && pump_dn)); // R6

    AST_PUMP_QUIET: assert property (@(posedge clk) disable iff (rst)
        t0 |-> (!pump_up && !pump_dn)); // R7

    AST_TEST_IDLE: assert property (@(posedge clk) disable iff (rst)
        !t1 |-> (!tst_cmp && !tst_div)); // R8

    AST_DIV_STEP: assert property (@(posedge clk) disable iff (rst)
        (vco_tick && (div_cnt != '0)) |=> (div_cnt == $past(div_cnt) - W'(1))); // R3

    AST_RELOAD_AT_TC: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur_ratio) |-> $past(div_ev)); // R4

    AST_RATIO_FLOOR: assert property (@(posedge clk) disable iff (rst)
        cur_ratio >= W'(MIN)); // R5

    AST_LOCK_ON_CMP: assert property (@(posedge clk) disable iff (rst)
        $rose(lock) |-> $past(ref_ev)); // R10
endmodule

bind synth_loop_core synth_loop_core_chk #(.W(RW), .MIN(MR)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .t0        (t0),
    .t1        (t1),
    .vco_tick  (vco_tick),
    .pump_up   (pump_up),
    .pump_dn   (pump_dn),
    .tst_cmp   (tst_cmp),
    .tst_div   (tst_div),
    .lock      (lock),
    .ref_ev    (ref_ev),
    .div_ev    (div_ev),
    .div_cnt   (div_cnt),
    .cur_ratio (cur_ratio)
);

// File: tb/synth_loop_core_tb.sv
module synth_loop_core_tb;
    localparam int RD = 512;
    localparam int LW = 8;
    localparam int LC = 4;
    localparam int MR = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_tick = 1'b0;
    logic        vco_tick = 1'b0;
    logic [14:0] ratio = 15'd128;
    logic        cp = 1'b0, t0 = 1'b0, t1 = 1'b0, os = 1'b0;
    logic        pump_up, pump_dn, pump_hi, drive_en, lock, tst_cmp, tst_div;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // stimulus control
    int cyc = 0;
    int rper = 1;
    bit von = 0;
    int vstart = 0;
    int vper = 1;
    int gap_lo = -1;
    int gap_hi = -1;

    // behavioural model state
    int m_rc, m_dc, m_cur, m_w, m_good;
    bit m_up, m_dn, m_bad, m_lk;

    always #5 clk = ~clk;

    synth_loop_core u_dut (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .vco_tick(vco_tick),
        .ratio(ratio), .cp(cp), .t0(t0), .t1(t1), .os(os),
        .pump_up(pump_up), .pump_dn(pump_dn), .pump_hi(pump_hi),
        .drive_en(drive_en), .lock(lock), .tst_cmp(tst_cmp), .tst_div(tst_div)
    );

    always @(posedge clk) begin
        bit rev, dev, pa, nu, nd, wide;
        int nw, eff;
        if (rst) begin
            m_rc = 0; m_dc = 0; m_cur = MR; m_w = 0; m_good = 0;
            m_up = 0; m_dn = 0; m_bad = 0; m_lk = 0;
        end else begin
            rev  = ref_tick && (m_rc == RD - 1);
            dev  = vco_tick && (m_dc == 0);
            pa   = m_up || m_dn;
            nu   = m_up || rev;
            nd   = m_dn || dev;
            if (nu && nd) begin nu = 0; nd = 0; end
            wide = pa && ref_tick && (m_w == LW - 1);
            if (!pa) nw = 0;
            else if (ref_tick && m_w < LW) nw = m_w + 1;
            else nw = m_w;
            if (rev) begin
                if (m_bad || wide) begin
                    m_good = 0; m_lk = 0;
                end else begin
                    if (m_good < LC) m_good++;
                    if (m_good >= LC) m_lk = 1;
                end
                m_bad = (nu || nd) && (nw >= LW);
            end else if (wide) begin
                m_bad = 1; m_good = 0; m_lk = 0;
            end
            m_w = nw;
            m_up = nu;
            m_dn = nd;
            if (ref_tick) m_rc = (m_rc + 1) % RD;
            if (vco_tick) begin
                if (m_dc == 0) begin
                    eff = (int'(ratio) < MR) ? MR : int'(ratio);
                    m_dc = eff - 1;
                    m_cur = eff;
                end else begin
                    m_dc = m_dc - 1;
                end
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R6 pump_up vs model", int'(pump_up), int'(m_up && !t0));
        chk("R6 pump_dn vs model", int'(pump_dn), int'(m_dn && !t0));
        chk("R9 pump_hi", int'(pump_hi), int'(cp));
        chk("R9 drive_en", int'(drive_en), int'(!os));
        chk("R10 lock vs model", int'(lock), int'(m_lk));
        chk("R2 tst_cmp vs model", int'(tst_cmp), int'(t1 && m_rc >= RD / 2));
        chk("R3 tst_div vs model", int'(tst_div), int'(t1 && (m_dc < m_cur / 2)));
    endtask

    task automatic step();
        ref_tick = ((cyc % rper) == 0);
        vco_tick = von && (cyc >= vstart) && (((cyc - vstart) % vper) == 0)
                   && !((cyc >= gap_lo) && (cyc < gap_hi));
        @(posedge clk);
        @(negedge clk);
        compare_all();
        cyc++;
    endtask

    task automatic run_to(input int k);
        while (cyc <= k) step();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        ref_tick = 1'b0;
        vco_tick = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cyc = 0;
        gap_lo = -1;
        gap_hi = -1;
    endtask

    initial begin
        int cnt;
        // R1: reset state
        do_reset();
        chk("R1 pump_up after reset", int'(pump_up), 0);
        chk("R1 pump_dn after reset", int'(pump_dn), 0);
        chk("R1 lock after reset", int'(lock), 0);
        chk("R1 tst_cmp after reset", int'(tst_cmp), 0);
        chk("R1 tst_div after reset", int'(tst_div), 0);

        // R2/R8: comparison clock routed, reference ticks on every other cycle
        t1 = 1; rper = 2; von = 0;
        cnt = 0;
        for (int i = 0; i < 2048; i++) begin step(); cnt += int'(tst_cmp); end
        chk("R2 comparison level high count", cnt, 1024);
        t1 = 0;
        step();
        chk("R8 tst_cmp idle without routing", int'(tst_cmp), 0);

        // R3: ratio 5, oscillator tick every cycle
        do_reset();
        rper = 1; ratio = 15'd5; von = 1; vstart = 0; vper = 1; t1 = 1;
        cnt = 0;
        for (int i = 0; i < 500; i++) begin step(); cnt += int'(tst_div); end
        chk("R3 divider level duty for ratio 5", cnt, 200);

        // R5: ratio 1 and ratio 0 clamp to 2
        do_reset();
        ratio = 15'd1;
        cnt = 0;
        for (int i = 0; i < 100; i++) begin step(); cnt += int'(tst_div); end
        chk("R5 ratio 1 behaves as 2", cnt, 50);
        do_reset();
        ratio = 15'd0;
        cnt = 0;
        for (int i = 0; i < 100; i++) begin step(); cnt += int'(tst_div); end
        chk("R5 ratio 0 behaves as 2", cnt, 50);

        // R4: mid-count ratio change is deferred to the terminal count
        do_reset();
        ratio = 15'd100;
        run_to(9);
        ratio = 15'd10;
        run_to(60);
        chk("R4 old period kept after change", int'(tst_div), 1);
        run_to(103);
        chk("R4 new ratio level low", int'(tst_div), 0);
        run_to(107);
        chk("R4 new ratio level high", int'(tst_div), 1);

        // R10/R11/R7/R9: near-aligned loop, then a phase slip
        do_reset();
        ratio = 15'd128; von = 1; vstart = 509; vper = 4; t1 = 0;
        run_to(1600);
        chk("R10 lock still low after three periods", int'(lock), 0);
        run_to(2100);
        chk("R10 lock high after four clean periods", int'(lock), 1);
        gap_lo = 2200; gap_hi = 2220;
        run_to(2560);
        chk("R11 lock held at start of wide pulse", int'(lock), 1);
        chk("R11 up pulse present", int'(pump_up), 1);
        run_to(2570);
        chk("R11 wide pulse clears lock", int'(lock), 0);
        run_to(2599);
        t0 = 1; cp = 1; os = 1;
        run_to(3075);
        chk("R7 pump silenced while comparator active", int'(pump_up), 0);
        chk("R9 high current selected", int'(pump_hi), 1);
        chk("R9 drive disabled", int'(drive_en), 0);
        run_to(3700);
        chk("R11 lock stays low with persistent offset", int'(lock), 0);
        t0 = 0; cp = 0; os = 0;

        // R6: coincident events produce no pulse and the loop locks
        do_reset();
        ratio = 15'd128; von = 1; vstart = 511; vper = 4;
        cnt = 0;
        for (int i = 0; i < 2600; i++) begin step(); cnt += int'(pump_up | pump_dn); end
        chk("R6 coincident events give no pump pulse", cnt, 0);
        chk("R10 lock with coincident events", int'(lock), 1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog R1..all actual=timeout expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule